// File: doc/BRIEF.md
# Masked Bit-Field Load/Store Unit

This unit carries out one of two byte-wide bit-field operations on a memory operand. An 8-bit immediate mask picks the field: each mask bit that is 1 belongs to the field, and the field is taken to be one contiguous run of ones. A load reads the addressed byte, gathers the field bits and returns them right-justified in an 8-bit result. A store reads the addressed byte, overwrites the field positions with the low-order bits of an 8-bit source value, and writes the merged byte back to the same address.

A host gives a command (operation, address, mask, source) while the unit reports that it is idle. The unit then steps through its memory transactions on a request/ready byte port and raises a one-cycle completion pulse. The field's alignment comes from the position of the lowest set bit of the mask. That position is found when the command is accepted.

Top module: `bitfield_rmw_unit`

## Requirements
- R1: `cmd_ready` is high exactly when the unit is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_valid` has no effect while `cmd_ready` is low.
- R2: In the cycle after a command is taken, `mem_req` is high for exactly one cycle with `mem_we` = 0 and `mem_addr` equal to the command address.
- R3: A request completes on the first clock edge after the request where `mem_ready` is high. For a read, `mem_rdata` is sampled only on that edge, and its value in any other cycle is ignored.
- R4: A load (`cmd_op` = 0) yields `result` = the masked bits of the read byte shifted right by the index of the mask's lowest set bit. Result bits above the field width are 0.
- R5: A store (`cmd_op` = 1) issues exactly one write, in the cycle after the read completes, to the same address. Every written bit outside the mask equals the bit that was read.
- R6: In a store, the masked positions receive source bits 0 upward in ascending order. Source bits beyond the field width do not affect the written byte.
- R7: A mask of 0 gives `result` = 0 on load. On store it writes back the read byte unchanged.
- R8: `done` is a one-cycle pulse in the cycle after the final `mem_ready` of the operation (the read for a load, the write for a store). `result` changes only at load completion.
- R9: A load issues no memory write (`mem_we` is never 1 with `mem_req` during a load).
- R10: After reset: `cmd_ready` = 1, `mem_req` = 0, `mem_we` = 0, `done` = 0, `result` = 0.
- R11: A command presented in the cycle `done` is high is taken on that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 1 | 0 = load field, 1 = store field |
| cmd_addr | input | ADDR_W | Byte address of the memory operand |
| cmd_mask | input | DATA_W | Field mask, contiguous ones |
| cmd_src | input | DATA_W | Source value for store |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory completes the outstanding request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Right-justified load field |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle, because `done` rises in the cycle the unit returns to idle. The bench keeps the next command on `cmd_valid` throughout the busy period, so that command sits there while it must be ignored and is then taken on the edge where `done` is high. The reference model predicts acceptance on exactly that edge. The bench judges the case from the timing of the following read request, the `cmd_ready` level and the `done` pulse, all compared every cycle. Memory latency changes between one and three cycles, so completions and new commands line up at several offsets.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } bfu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bfu_state_e;
endpackage

// File: rtl/bfu_lsb_find.sv
module bfu_lsb_find #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [W-1:0]  mask,
  output logic [SW-1:0] idx
);
  // Priority chain from bit 0 upward: the first set bit fixes the index.
  logic [W:0]    seen;
  logic [SW-1:0] part [W+1];

  assign seen[0] = 1'b0;
  assign part[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_chain
    assign seen[g+1] = seen[g] | mask[g];
    assign part[g+1] = (!seen[g] && mask[g]) ? SW'(g) : part[g];
  end

  assign idx = part[W];

  always_comb begin
    if (seen[W]) begin
      // R4
      lsb_set_chk: assert (mask[idx]);
      // R4
      lsb_low_clear_chk: assert ((mask & ~({W{1'b1}} << idx)) == '0);
    end
  end
endmodule

// File: rtl/bfu_field_path.sv
module bfu_field_path #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [W-1:0]  mask,
  input  logic [SW-1:0] shift,
  input  logic [W-1:0]  rd_byte,
  input  logic [W-1:0]  src,
  output logic [W-1:0]  ext,
  output logic [W-1:0]  merged
);
  logic [W-1:0] placed;

  always_comb begin
    ext    = (rd_byte & mask) >> shift;
    placed = (src << shift) & mask;
    merged = (rd_byte & ~mask) | placed;
  end
endmodule

// File: rtl/bfu_seq.sv
module bfu_seq
  import bfu_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [W-1:0]  cmd_mask,
  input  logic [W-1:0]  cmd_src,
  input  logic [SW-1:0] cmd_shift,
  output logic          cmd_ready,
  output logic [W-1:0]  mask_q,
  output logic [SW-1:0] shift_q,
  output logic [W-1:0]  src_q,
  input  logic [W-1:0]  ext,
  input  logic [W-1:0]  merged,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ready,
  input  logic [W-1:0]  mem_rdata,
  output logic          done,
  output logic [W-1:0]  result
);
  bfu_state_e state;
  bfu_op_e    op_q;

  assign cmd_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_LOAD;
      mask_q    <= '0;
      shift_q   <= '0;
      src_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      result    <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q     <= bfu_op_e'(cmd_op);
            mask_q   <= cmd_mask;
            shift_q  <= cmd_shift;
            src_q    <= cmd_src;
            mem_addr <= cmd_addr;
            mem_we   <= 1'b0;
            mem_req  <= 1'b1;
            state    <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_ready) begin
            if (op_q == OP_STORE) begin
              mem_wdata <= merged;
              mem_we    <= 1'b1;
              mem_req   <= 1'b1;
              state     <= ST_WR;
            end else begin
              result <= ext;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        ST_WR: begin
          if (mem_ready) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mem_req);

  // R9
  load_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (op_q == OP_STORE));

  // R5
  keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (((mem_wdata ^ $past(mem_rdata)) & ~mask_q) == '0));

  // R2
  read_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> ($past(cmd_valid) && $past(cmd_ready) &&
                              mem_addr == $past(cmd_addr)));
endmodule

// File: rtl/bitfield_rmw_unit.sv
module bitfield_rmw_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic [DATA_W-1:0] cmd_src,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int SHIFT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [SHIFT_W-1:0] cmd_shift;
  logic [SHIFT_W-1:0] shift_q;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  src_q;
  logic [DATA_W-1:0]  ext;
  logic [DATA_W-1:0]  merged;

  bfu_lsb_find #(.W(DATA_W), .SW(SHIFT_W)) u_scan (
    .mask (cmd_mask),
    .idx  (cmd_shift)
  );

  bfu_field_path #(.W(DATA_W), .SW(SHIFT_W)) u_path (
    .mask    (mask_q),
    .shift   (shift_q),
    .rd_byte (mem_rdata),
    .src     (src_q),
    .ext     (ext),
    .merged  (merged)
  );

  bfu_seq #(.AW(ADDR_W), .W(DATA_W), .SW(SHIFT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_mask  (cmd_mask),
    .cmd_src   (cmd_src),
    .cmd_shift (cmd_shift),
    .cmd_ready (cmd_ready),
    .mask_q    (mask_q),
    .shift_q   (shift_q),
    .src_q     (src_q),
    .ext       (ext),
    .merged    (merged),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .done      (done),
    .result    (result)
  );
endmodule

// File: tb/bitfield_rmw_unit_bench.sv
`timescale 1ns/1ps
module bitfield_rmw_unit_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NCMD = 12;
  localparam int NSTORE = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_mask = '0;
  logic [DW-1:0] cmd_src = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          done;
  logic [DW-1:0] result;

  always #2 clk = ~clk;

  bitfield_rmw_unit #(.ADDR_W(AW), .DATA_W(DW)) u_bitfield_rmw_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .cmd_src(cmd_src),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done), .result(result)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] mem [256];
  logic       c_op   [NCMD];
  logic [7:0] c_addr [NCMD];
  logic [7:0] c_mask [NCMD];
  logic [7:0] c_src  [NCMD];
  int         c_gap  [NCMD];

  // reference model state
  int ph = 0;
  logic m_op = 1'b0;
  logic [7:0] m_mask = '0, m_src = '0;
  logic e_req = 0, e_we = 0, e_done = 0;
  logic [7:0] e_addr = '0, e_wdata = '0, e_result = '0;
  logic acc = 1'b0;
  // memory model state
  int mp_busy = 0, mp_cnt = 0, lat_sel = 0;
  logic mp_we = 1'b0;
  logic [7:0] mp_addr = '0, mp_wdata = '0;
  // run control
  int ci = 0, gapc = 0, cyc = 0, n_done = 0, n_writes = 0, endcnt = 0;

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] ref_extract(input logic [7:0] m, input logic [7:0] d);
    logic [7:0] r = '0;
    int k = 0;
    for (int i = 0; i < 8; i++) if (m[i]) begin r[k] = d[i]; k++; end
    return r;
  endfunction

  function automatic logic [7:0] ref_insert(input logic [7:0] m, input logic [7:0] d,
                                            input logic [7:0] s);
    logic [7:0] r = d;
    int k = 0;
    for (int i = 0; i < 8; i++) if (m[i]) begin r[i] = s[k]; k++; end
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic set_cmd(input int i, input logic op, input logic [7:0] a,
                         input logic [7:0] m, input logic [7:0] s, input int g);
    c_op[i] = op; c_addr[i] = a; c_mask[i] = m; c_src[i] = s; c_gap[i] = g;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = init_val(a);
    set_cmd(0,  1'b0, 8'd10, 8'h3C, 8'h00, 2);
    set_cmd(1,  1'b1, 8'd10, 8'h3C, 8'hFF, 0);  // R6 high source bits set
    set_cmd(2,  1'b0, 8'd10, 8'h3C, 8'h00, 0);
    set_cmd(3,  1'b0, 8'd20, 8'h00, 8'h00, 1);  // R7
    set_cmd(4,  1'b1, 8'd20, 8'h00, 8'hAA, 0);  // R7
    set_cmd(5,  1'b0, 8'd30, 8'hFF, 8'h00, 3);
    set_cmd(6,  1'b1, 8'd31, 8'h80, 8'h03, 0);
    set_cmd(7,  1'b1, 8'd32, 8'h01, 8'h02, 0);
    set_cmd(8,  1'b0, 8'd32, 8'h01, 8'h00, 1);
    set_cmd(9,  1'b1, 8'd33, 8'hF0, 8'h5A, 0);
    set_cmd(10, 1'b0, 8'd33, 8'hF0, 8'h00, 0);
    set_cmd(11, 1'b0, 8'd34, 8'h0E, 8'h00, 2);
    gapc = c_gap[0];
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc < 4) begin
      if (cyc == 3) begin
        chk("R10 cmd_ready", int'(cmd_ready), 1);
        chk("R10 mem_req", int'(mem_req), 0);
        chk("R10 mem_we", int'(mem_we), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 result", int'(result), 0);
      end
    end else begin
      if (cyc == 4) rst = 1'b0;
      // compare against the prediction made one cycle ago
      chk((e_done && ph == 0) ? "R11 cmd_ready" : "R1 cmd_ready", int'(cmd_ready), int'(ph == 0));
      chk("R2 mem_req", int'(mem_req), int'(e_req));
      chk("R9 mem_we", int'(mem_we), int'(e_we));
      chk("R2 mem_addr", int'(mem_addr), int'(e_addr));
      chk(m_mask == 0 ? "R7 mem_wdata" : "R6 mem_wdata", int'(mem_wdata), int'(e_wdata));
      chk("R3 R8 done", int'(done), int'(e_done));
      chk(m_mask == 0 ? "R7 result" : "R4 result", int'(result), int'(e_result));
      if (done) n_done++;

      // memory model: rdata is junk except in the ready cycle
      mem_ready = 1'b0;
      mem_rdata = 8'(8'h5C ^ cyc);
      if (mp_busy != 0) begin
        mp_cnt--;
        if (mp_cnt == 0) begin
          mem_ready = 1'b1;
          if (mp_we) begin mem[mp_addr] = mp_wdata; n_writes++; end
          else mem_rdata = mem[mp_addr];
          mp_busy = 0;
        end
      end
      if (mem_req) begin
        mp_busy = 1; mp_we = mem_we; mp_addr = mem_addr; mp_wdata = mem_wdata;
        mp_cnt = 1 + (lat_sel % 3);
        lat_sel++;
      end

      // command driver: next command stays on the port while the unit is busy (R1)
      if (acc) begin
        cmd_valid = 1'b0;
        ci++;
        gapc = (ci < NCMD) ? c_gap[ci] : 0;
        acc = 1'b0;
      end
      if (!cmd_valid && ci < NCMD) begin
        if (gapc == 0) begin
          cmd_valid = 1'b1; cmd_op = c_op[ci]; cmd_addr = c_addr[ci];
          cmd_mask = c_mask[ci]; cmd_src = c_src[ci];
        end else gapc--;
      end

      // reference model step for the coming edge
      e_req = 1'b0;
      e_done = 1'b0;
      case (ph)
        0: if (cmd_valid) begin
             m_op = cmd_op; m_mask = cmd_mask; m_src = cmd_src;
             e_req = 1'b1; e_we = 1'b0; e_addr = cmd_addr; ph = 1; acc = 1'b1;
           end
        1: if (mem_ready) begin
             if (m_op) begin
               e_wdata = ref_insert(m_mask, mem_rdata, m_src);
               e_req = 1'b1; e_we = 1'b1; ph = 2;
             end else begin
               e_result = ref_extract(m_mask, mem_rdata);
               e_done = 1'b1; ph = 0;
             end
           end
        default: if (mem_ready) begin e_done = 1'b1; ph = 0; end
      endcase

      if (n_done == NCMD && ph == 0) begin
        endcnt++;
        if (endcnt == 3) begin
          chk("R5 write count", n_writes, NSTORE);
          chk("R6 mem[10]", int'(mem[10]), int'(ref_insert(8'h3C, init_val(10), 8'hFF)));
          chk("R7 mem[20] unchanged", int'(mem[20]), int'(init_val(20)));
          chk("R5 mem[31]", int'(mem[31]), int'((init_val(31) & 8'h7F) | 8'h80));
          chk("R6 mem[33]", int'(mem[33]), int'((init_val(33) & 8'h0F) | 8'hA0));
          finish_run();
        end
      end
      if (cyc > 4000) begin
        n_chk++;
        n_err++;
        $display("FAIL R8 watchdog: actual=%0d completions expected=%0d", n_done, NCMD);
        finish_run();
      end
    end
  end
endmodule